// File: doc/BRIEF.md
# Segmented Pipelined Wakeup Window

This block is the wakeup half of an out-of-order issue queue. It holds a fixed pool of waiting instructions. Each one has two source operand tags and a ready bit per operand. Every cycle up to W result tags arrive, each with its own valid bit. An operand whose tag equals one of those results becomes ready. An entry whose two operands are both ready raises its bit in the ready vector, and select logic outside the block reads that vector.

The window is cut into SEGS groups of entries, with a row of tag registers between neighbouring groups. A broadcast tag set is compared in group 0 in the cycle it arrives. One cycle later it is compared in group 1, and so on. After the last group it is dropped. The entry-to-group map spreads entries evenly: entry `e` lives in group `floor(e*SEGS/ENTRIES)`. When an entry is loaded, its two tags are also compared against every tag still travelling down the chain, including the tags at the input in that cycle. This means a producer result that has already passed the entry's group is not lost. Select logic clears an entry when it issues it.

Top module: `wkw_window`

## Requirements
- R1: While reset is high, and in the cycle after it, every bit of `ready_o` is 0. Reset also empties the tag registers, so a tag broadcast before reset cannot wake an entry loaded afterwards.
- R2: Loading an entry with both initial ready bits set makes its `ready_o` bit 1 in the cycle after the load.
- R3: A valid tag broadcast in cycle t is compared in group s in cycle t+s. A matching operand that completes entry `e`, in group s = floor(e*SEGS/ENTRIES), makes `ready_o[e]` 1 from cycle t+s+1 onward, and not earlier.
- R4: An entry reports ready only when both operands are ready. One operand matching leaves its `ready_o` bit at 0.
- R5: A broadcast lane whose valid bit is 0 never marks any operand ready, whatever tag it carries.
- R6: All W lanes are compared in parallel. The two operands of one entry can be woken by two different lanes in the same cycle.
- R7: An entry loaded in cycle t+k, 0 <= k < SEGS, with a source tag broadcast in cycle t, has that operand ready from the load onward, even when the tag has already passed the entry's group.
- R8: A tag broadcast in cycle t is gone by cycle t+SEGS. An entry loaded then with that tag does not see it.
- R9: Clearing an entry makes its `ready_o` bit 0 in the next cycle. The bit stays 0 until the entry is loaded again. When a clear and a load name the same entry in one cycle, the clear wins.
- R10: Once `ready_o[e]` is 1, it stays 1 until entry e is cleared or reloaded, whatever is broadcast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Load an entry this cycle |
| wr_idx_i | input | IDX_W | Entry to load |
| wr_src0_tag_i | input | TAG_W | Tag of source operand 0 |
| wr_src1_tag_i | input | TAG_W | Tag of source operand 1 |
| wr_src0_rdy_i | input | 1 | Operand 0 already available at load |
| wr_src1_rdy_i | input | 1 | Operand 1 already available at load |
| bc_vld_i | input | W | Per-lane valid of broadcast result tags |
| bc_tag_i | input | W*TAG_W | Broadcast result tags, lane l at bits [l*TAG_W +: TAG_W] |
| clr_en_i | input | 1 | Clear an entry this cycle |
| clr_idx_i | input | IDX_W | Entry to clear |
| ready_o | output | ENTRIES | Registered per-entry ready vector |

## Verification
The embedded properties cover the following on every cycle:
- each row of tag registers copies the row before it;
- a cleared entry drops its ready bit;
- a ready bit never falls on its own;
- a ready bit never rises unless a load happened or a valid tag sat at the entry's own group;
- the whole vector is zero after reset.

Only the bench scenarios can show the exact rise cycle for each of the 32 positions. They can also show that a tag loaded k cycles late is still caught for k below SEGS and missed at SEGS. For these, the bench compares `ready_o` every cycle against a history-based model in which group s looks at the broadcast from s cycles earlier.

// File: rtl/wkw_pkg.sv
package wkw_pkg;

  // Largest supported number of window groups.
  localparam int MAX_SEGS = 10;

  // Even spread of entries over groups: entry idx sits in this group.
  function automatic int seg_of(input int idx, input int entries, input int segs);
    return (idx * segs) / entries;
  endfunction

endpackage

// File: rtl/wkw_tag_pipe.sv
// Chain of tag registers. Row 0 is the broadcast input itself; row k holds
// the tag set that arrived k cycles ago. Rows are flattened on the outputs.
module wkw_tag_pipe #(
  parameter int W     = 4,
  parameter int TAG_W = 6,
  parameter int SEGS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [W-1:0]            in_vld_i,
  input  logic [W*TAG_W-1:0]      in_tag_i,
  output logic [SEGS*W-1:0]       st_vld_o,
  output logic [SEGS*W*TAG_W-1:0] st_tag_o
);

  localparam int ROW_T = W * TAG_W;
  localparam int LAT_N = (SEGS > 1) ? SEGS - 1 : 1;

  logic [W-1:0]     lat_vld [LAT_N];
  logic [ROW_T-1:0] lat_tag [LAT_N];
  logic             run_q;

  always_ff @(posedge clk) run_q <= !rst;

  assign st_vld_o[W-1:0]     = in_vld_i;
  assign st_tag_o[ROW_T-1:0] = in_tag_i;

  generate
    if (SEGS > 1) begin : g_chain
      for (genvar k = 1; k < SEGS; k++) begin : g_row
        always_ff @(posedge clk) begin
          if (rst) begin
            lat_vld[k-1] <= '0;
          end else begin
            lat_vld[k-1] <= st_vld_o[(k-1)*W +: W];
          end
          lat_tag[k-1] <= st_tag_o[(k-1)*ROW_T +: ROW_T];
        end

        assign st_vld_o[k*W +: W]         = lat_vld[k-1];
        assign st_tag_o[k*ROW_T +: ROW_T] = lat_tag[k-1];

        // R3: each row moves exactly one group further per cycle
        p_tag_advance_r3: assert property (@(posedge clk) disable iff (rst)
          run_q |-> (st_vld_o[k*W +: W] == $past(st_vld_o[(k-1)*W +: W])));
      end
    end else begin : g_flat
      assign lat_vld[0] = '0;
      assign lat_tag[0] = '0;
    end
  endgenerate

endmodule

// File: rtl/wkw_entry.sv
// One window slot: two source tags, two ready bits, a valid bit and a
// registered ready output. SEG selects which tag row it listens to.
module wkw_entry #(
  parameter int W     = 4,
  parameter int TAG_W = 6,
  parameter int SEGS  = 4,
  parameter int SEG   = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SEGS*W-1:0]       st_vld_i,
  input  logic [SEGS*W*TAG_W-1:0] st_tag_i,
  input  logic                    wr_hit_i,
  input  logic [TAG_W-1:0]        wr_tag0_i,
  input  logic [TAG_W-1:0]        wr_tag1_i,
  input  logic                    wr_rdy0_i,
  input  logic                    wr_rdy1_i,
  input  logic                    clr_hit_i,
  output logic                    rdy_o
);

  localparam int LANES = SEGS * W;
  localparam int BASE  = SEG * W;

  logic             vld_q, r0_q, r1_q, rdy_q;
  logic [TAG_W-1:0] tag0_q, tag1_q;
  logic             seg_hit0, seg_hit1, fly_hit0, fly_hit1;
  logic             nxt_vld, nxt_r0, nxt_r1;

  // Compare the stored tags with the row belonging to this group only.
  always_comb begin
    seg_hit0 = 1'b0;
    seg_hit1 = 1'b0;
    for (int l = 0; l < W; l++) begin
      if (st_vld_i[BASE+l] && (st_tag_i[(BASE+l)*TAG_W +: TAG_W] == tag0_q)) seg_hit0 = 1'b1;
      if (st_vld_i[BASE+l] && (st_tag_i[(BASE+l)*TAG_W +: TAG_W] == tag1_q)) seg_hit1 = 1'b1;
    end
  end

  // Compare incoming tags with everything still travelling on the chain.
  always_comb begin
    fly_hit0 = 1'b0;
    fly_hit1 = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (st_vld_i[l] && (st_tag_i[l*TAG_W +: TAG_W] == wr_tag0_i)) fly_hit0 = 1'b1;
      if (st_vld_i[l] && (st_tag_i[l*TAG_W +: TAG_W] == wr_tag1_i)) fly_hit1 = 1'b1;
    end
  end

  always_comb begin
    nxt_vld = vld_q;
    nxt_r0  = r0_q | seg_hit0;
    nxt_r1  = r1_q | seg_hit1;
    if (wr_hit_i) begin
      nxt_vld = 1'b1;
      nxt_r0  = wr_rdy0_i | fly_hit0;
      nxt_r1  = wr_rdy1_i | fly_hit1;
    end
    if (clr_hit_i) begin
      nxt_vld = 1'b0;
      nxt_r0  = 1'b0;
      nxt_r1  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      r0_q  <= 1'b0;
      r1_q  <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      vld_q <= nxt_vld;
      r0_q  <= nxt_r0;
      r1_q  <= nxt_r1;
      rdy_q <= nxt_vld & nxt_r0 & nxt_r1;
    end
    if (wr_hit_i && !clr_hit_i) begin
      tag0_q <= wr_tag0_i;
      tag1_q <= wr_tag1_i;
    end
  end

  assign rdy_o = rdy_q;

  // R9: a clear always wins and drops readiness next cycle
  p_clear_drops_r9: assert property (@(posedge clk) disable iff (rst)
    clr_hit_i |=> !rdy_o);

  // R10: readiness is held until the slot is cleared or reloaded
  p_ready_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && !clr_hit_i && !wr_hit_i) |=> rdy_o);

  // R5: with no valid lane at this group and no load, readiness cannot rise
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    (!rdy_o && !wr_hit_i && (st_vld_i[BASE +: W] == '0)) |=> !rdy_o);

  // R2: a load with both operands available is ready at once
  p_load_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_hit_i && !clr_hit_i && wr_rdy0_i && wr_rdy1_i) |=> rdy_o);

endmodule

// File: rtl/wkw_window.sv
module wkw_window #(
  parameter int ENTRIES = 32,
  parameter int SEGS    = 4,
  parameter int W       = 4,
  parameter int TAG_W   = 6,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [TAG_W-1:0]     wr_src0_tag_i,
  input  logic [TAG_W-1:0]     wr_src1_tag_i,
  input  logic                 wr_src0_rdy_i,
  input  logic                 wr_src1_rdy_i,
  input  logic [W-1:0]         bc_vld_i,
  input  logic [W*TAG_W-1:0]   bc_tag_i,
  input  logic                 clr_en_i,
  input  logic [IDX_W-1:0]     clr_idx_i,
  output logic [ENTRIES-1:0]   ready_o
);

  import wkw_pkg::*;

  localparam int LANES = SEGS * W;

  logic [LANES-1:0]       st_vld;
  logic [LANES*TAG_W-1:0] st_tag;
  logic [ENTRIES-1:0]     wr_hit, clr_hit;

  wkw_tag_pipe #(.W(W), .TAG_W(TAG_W), .SEGS(SEGS)) tag_pipe_i (
    .clk      (clk),
    .rst      (rst),
    .in_vld_i (bc_vld_i),
    .in_tag_i (bc_tag_i),
    .st_vld_o (st_vld),
    .st_tag_o (st_tag)
  );

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      wr_hit[e]  = wr_en_i  && (wr_idx_i  == IDX_W'(e));
      clr_hit[e] = clr_en_i && (clr_idx_i == IDX_W'(e));
    end
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      wkw_entry #(
        .W     (W),
        .TAG_W (TAG_W),
        .SEGS  (SEGS),
        .SEG   (seg_of(e, ENTRIES, SEGS))
      ) slot_i (
        .clk       (clk),
        .rst       (rst),
        .st_vld_i  (st_vld),
        .st_tag_i  (st_tag),
        .wr_hit_i  (wr_hit[e]),
        .wr_tag0_i (wr_src0_tag_i),
        .wr_tag1_i (wr_src1_tag_i),
        .wr_rdy0_i (wr_src0_rdy_i),
        .wr_rdy1_i (wr_src1_rdy_i),
        .clr_hit_i (clr_hit[e]),
        .rdy_o     (ready_o[e])
      );
    end
  endgenerate

  // R1: reset leaves the whole vector clear
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ready_o == '0));

  // R9: the slot named by the clear port is not ready afterwards
  p_clear_port_r9: assert property (@(posedge clk) disable iff (rst)
    clr_en_i |=> !ready_o[$past(clr_idx_i)]);

endmodule

// File: tb/wkw_window_tb_top.sv
module wkw_window_tb_top;
  localparam int N  = 32;
  localparam int S  = 4;
  localparam int W  = 4;
  localparam int TW = 6;
  localparam int IW = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [IW-1:0]   wr_idx = '0;
  logic [TW-1:0]   wr_t0 = '0, wr_t1 = '0;
  logic            wr_r0 = 1'b0, wr_r1 = 1'b0;
  logic [W-1:0]    bc_vld = '0;
  logic [W*TW-1:0] bc_tag = '0;
  logic            clr_en = 1'b0;
  logic [IW-1:0]   clr_idx = '0;
  logic [N-1:0]    ready;

  always #2 clk = ~clk;

  wkw_window #(.ENTRIES(N), .SEGS(S), .W(W), .TAG_W(TW)) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_src0_tag_i(wr_t0), .wr_src1_tag_i(wr_t1),
    .wr_src0_rdy_i(wr_r0), .wr_src1_rdy_i(wr_r1),
    .bc_vld_i(bc_vld), .bc_tag_i(bc_tag),
    .clr_en_i(clr_en), .clr_idx_i(clr_idx), .ready_o(ready)
  );

  // Reference state: entries plus a history of the last S broadcasts.
  bit            m_vld [N];
  bit            m_r0  [N];
  bit            m_r1  [N];
  logic [TW-1:0] m_t0  [N];
  logic [TW-1:0] m_t1  [N];
  bit            h_vld [S][W];
  logic [TW-1:0] h_tag [S][W];
  int n_chk = 0;
  int n_err = 0;

  function automatic int grp(int e);
    return (e * S) / N;
  endfunction

  function automatic bit hist_hit(int k, logic [TW-1:0] t);
    for (int l = 0; l < W; l++) if (h_vld[k][l] && h_tag[k][l] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit fly_hit(logic [TW-1:0] t);
    for (int k = 0; k < S; k++) if (hist_hit(k, t)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v;
    for (int e = 0; e < N; e++) v[e] = m_vld[e] & m_r0[e] & m_r1[e];
    return v;
  endfunction

  task automatic model_step();
    if (rst) begin
      for (int e = 0; e < N; e++) begin m_vld[e] = 0; m_r0[e] = 0; m_r1[e] = 0; end
      for (int k = 0; k < S; k++) for (int l = 0; l < W; l++) h_vld[k][l] = 0;
      return;
    end
    for (int k = S - 1; k > 0; k--)
      for (int l = 0; l < W; l++) begin h_vld[k][l] = h_vld[k-1][l]; h_tag[k][l] = h_tag[k-1][l]; end
    for (int l = 0; l < W; l++) begin h_vld[0][l] = bc_vld[l]; h_tag[0][l] = bc_tag[l*TW +: TW]; end
    for (int e = 0; e < N; e++) begin
      if (clr_en && clr_idx == IW'(e)) begin
        m_vld[e] = 0; m_r0[e] = 0; m_r1[e] = 0;
      end else if (wr_en && wr_idx == IW'(e)) begin
        m_vld[e] = 1; m_t0[e] = wr_t0; m_t1[e] = wr_t1;
        m_r0[e] = wr_r0 | fly_hit(wr_t0);
        m_r1[e] = wr_r1 | fly_hit(wr_t1);
      end else if (m_vld[e]) begin
        m_r0[e] = m_r0[e] | hist_hit(grp(e), m_t0[e]);
        m_r1[e] = m_r1[e] | hist_hit(grp(e), m_t1[e]);
      end
    end
  endtask

  task automatic idle();
    wr_en = 0; clr_en = 0; bc_vld = '0; bc_tag = '0;
    wr_t0 = '0; wr_t1 = '0; wr_r0 = 0; wr_r1 = 0;
  endtask

  task automatic chk(string lab, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", lab, act, exp);
    end
  endtask

  // One clock: inputs set beforehand are sampled, the model advances and
  // the whole vector is compared well away from the edge.
  task automatic tick(string lab);
    logic [N-1:0] exp;
    @(posedge clk);
    #1;
    model_step();
    idle();
    exp = model_vec();
    n_chk++;
    if (ready !== exp) begin
      n_err++;
      $display("FAIL %s: ready actual=%h expected=%h", lab, ready, exp);
    end
  endtask

  task automatic ld(int idx, int t0, int t1, bit r0, bit r1);
    wr_en = 1; wr_idx = IW'(idx); wr_t0 = TW'(t0); wr_t1 = TW'(t1); wr_r0 = r0; wr_r1 = r1;
  endtask

  task automatic bc(int lane, int t);
    bc_vld[lane] = 1'b1; bc_tag[lane*TW +: TW] = TW'(t);
  endtask

  task automatic clr(int idx);
    clr_en = 1; clr_idx = IW'(idx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle();
    // R1: reset state
    repeat (3) tick("R1");
    for (int e = 0; e < N; e++) chk("R1", ready[e], 1'b0);
    rst = 0;
    tick("R1");
    // R1: a tag in flight when reset hits is lost
    bc(0, 7); tick("R1");
    tick("R1");
    rst = 1; tick("R1"); rst = 0;
    ld(31, 7, 0, 0, 1); tick("R1");
    repeat (S) tick("R1");
    chk("R1", ready[31], 1'b0);
    clr(31); tick("R1");

    // R2: load with both operands ready
    ld(5, 1, 2, 1, 1); tick("R2");
    chk("R2", ready[5], 1'b1);
    clr(5); tick("R2");

    // R3: rise cycle for every position in the window
    for (int e = 0; e < N; e++) begin ld(e, 0, e + 1, 1, 0); tick("R3"); end
    repeat (S) tick("R3");
    for (int e = 0; e < N; e++) begin
      bc(e % W, e + 1);
      for (int d = 1; d <= S + 1; d++) begin
        tick("R3");
        chk("R3", ready[e], (d >= grp(e) + 1));
      end
    end
    for (int e = 0; e < N; e++) begin clr(e); tick("R9"); end

    // R4: one operand is not enough
    ld(2, 10, 11, 0, 0); tick("R4");
    bc(0, 10); tick("R4");
    repeat (S) tick("R4");
    chk("R4", ready[2], 1'b0);
    bc(1, 11); tick("R4");
    chk("R4", ready[2], 1'b1);
    clr(2); tick("R4");

    // R5: a lane with its valid bit low carries a matching tag
    ld(9, 12, 13, 1, 0); tick("R5");
    bc_tag[2*TW +: TW] = TW'(13); tick("R5");
    repeat (S) tick("R5");
    chk("R5", ready[9], 1'b0);
    clr(9); tick("R5");

    // R6: two lanes wake the two operands together (entry 20 is group 2)
    ld(20, 14, 15, 0, 0); tick("R6");
    bc(3, 14); bc(1, 15); tick("R6");
    tick("R6");
    chk("R6", ready[20], 1'b0);
    tick("R6");
    chk("R6", ready[20], 1'b1);
    clr(20); tick("R6");

    // R7 / R8: load k cycles after the broadcast into group 0
    for (int k = 0; k <= S; k++) begin
      bc(0, 20 + k);
      if (k > 0) begin
        tick("R7");
        repeat (k - 1) tick("R7");
      end
      ld(0, 20 + k, 0, 0, 1); tick("R7");
      if (k < S) chk("R7", ready[0], 1'b1);
      else       chk("R8", ready[0], 1'b0);
      clr(0); tick("R8");
      repeat (S) tick("R8");
    end

    // R9: clear drops readiness; clear beats a load of the same slot
    ld(3, 30, 31, 1, 1); tick("R9");
    chk("R9", ready[3], 1'b1);
    clr(3); tick("R9");
    chk("R9", ready[3], 1'b0);
    clr(4); ld(4, 32, 33, 1, 1); tick("R9");
    chk("R9", ready[4], 1'b0);
    bc(0, 32); bc(1, 33); tick("R9");
    tick("R9");
    chk("R9", ready[4], 1'b0);

    // R10: readiness holds under unrelated and repeated broadcasts
    ld(6, 34, 35, 1, 1); tick("R10");
    for (int i = 0; i < 10; i++) begin
      bc(i % W, 34 + (i % 3)); ld(7 + i, 40, 41, 0, 0); tick("R10");
    end
    chk("R10", ready[6], 1'b1);
    for (int e = 0; e < N; e++) begin clr(e); tick("R10"); end

    // Mixed traffic against the timing model
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 3 == 0) ld($urandom % N, $urandom % 16, $urandom % 16,
                                 ($urandom % 4) == 0, ($urandom % 4) == 0);
      if ($urandom % 5 == 0) clr($urandom % N);
      for (int l = 0; l < W; l++) begin
        bc_tag[l*TW +: TW] = TW'($urandom % 16);
        bc_vld[l] = ($urandom % 3) == 0;
      end
      tick("R3");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule